// File: doc/BRIEF.md
# Predicated Register Move Sequencer

This block carries out one register-to-register move across an external register file. A small table of tag slots decides, by register number, whether a register stands for a single value or for the base of a vector. A vector of length `vl` holds `vl` consecutive register-file entries beginning at its base index. Once the block has latched the operand kinds at the start strobe, it walks the elements one per cycle. A per-element predicate may gate the source side, the destination side, or both.

The one move operation therefore gives seven patterns with no other opcode: splat, sparse splat and insert (scalar into vector), extract (vector into scalar), and copy, gather and scatter (vector into vector). Each cycle the block issues at most one register-file read and one write. A one-cycle `done` pulse marks the end of the move.

Top module: `pred_move_seq`

## Requirements
- R1: A register counts as a vector when at least one enabled tag slot holds its index. Two slots may hold the same index. Operand kinds, masks, indices and `vl` are captured at the accepted start.
- R2: With a scalar source, a vector destination and the destination predicate off, destination elements 0..vl-1 all receive the scalar value (splat).
- R3: With a scalar source and the destination predicate on, only destination elements whose bit `dst_pred[i]` is 1 receive the scalar, and the others keep their value. A one-hot mask therefore inserts into exactly one element.
- R4: With a vector source and a scalar destination, the scalar receives source element k. Here k is the lowest set bit of `src_pred` below `vl` when the source predicate is on, and 0 when it is off (extract).
- R5: With both operands vectors and no predicate, destination element i receives source element i for every i < vl (copy).
- R6: In a vector-to-vector move with the source predicate on, source elements whose bit is 0 are skipped, and the enabled ones land in consecutive destination elements (gather).
- R7: In a vector-to-vector move with the destination predicate on, consecutive source elements are written only into destination elements whose bit is 1. When both predicates are on, enabled source elements pair in order with enabled destination elements.
- R8: A predicate on a scalar operand has no effect. A scalar-to-scalar move writes the destination exactly once.
- R9: A predicate enabled on a vector operand with an all-zero mask, or a `vl` of 0, produces no register write, and `done` is still pulsed.
- R10: After reset `busy` and `done` are low. The move ends when the source or destination element index reaches `vl` (or after the single scalar-destination write). `done` then pulses for exactly one cycle, and no write occurs outside the move.
- R11: A start strobe that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_we | input | 1 | Write strobe for one tag slot |
| tag_slot | input | TW | Tag slot being written |
| tag_reg | input | AW | Register index stored in the slot |
| tag_on | input | 1 | Enables the slot |
| start | input | 1 | Start strobe, accepted when idle |
| src_reg | input | AW | Source register (base) index |
| dst_reg | input | AW | Destination register (base) index |
| src_pred_en | input | 1 | Source predicate in use |
| src_pred | input | MAXVL | Source element mask |
| dst_pred_en | input | 1 | Destination predicate in use |
| dst_pred | input | MAXVL | Destination element mask |
| vl | input | LW | Element count, 0..MAXVL |
| rf_raddr | output | AW | Register-file read address |
| rf_rdata | input | DW | Register-file read data, combinational from `rf_raddr` |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | AW | Register-file write address |
| rf_wdata | output | DW | Register-file write data |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `vl` never exceeds MAXVL when a start is accepted. They also assume that the register file returns read data in the same cycle as the address. The bench keeps `vl` in 0..MAXVL and models the register file as an array read without delay and written on the clock edge. It places the source and destination spans in disjoint parts of the file. It sweeps every operand-kind pairing, every predicate combination and a spread of masks, including empty and one-hot masks. It also re-strobes `start` with other indices during each move.

// File: rtl/pred_move_seq.sv
module pred_move_seq #(
  parameter int DW = 16,
  parameter int AW = 5,
  parameter int MAXVL = 8,
  parameter int NTAG = 4,
  localparam int LW = $clog2(MAXVL + 1),
  localparam int TW = (NTAG > 1) ? $clog2(NTAG) : 1,
  localparam int MW = 1 << LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tag_we,
  input  logic [TW-1:0]    tag_slot,
  input  logic [AW-1:0]    tag_reg,
  input  logic             tag_on,
  input  logic             start,
  input  logic [AW-1:0]    src_reg,
  input  logic [AW-1:0]    dst_reg,
  input  logic             src_pred_en,
  input  logic [MAXVL-1:0] src_pred,
  input  logic             dst_pred_en,
  input  logic [MAXVL-1:0] dst_pred,
  input  logic [LW-1:0]    vl,
  output logic [AW-1:0]    rf_raddr,
  input  logic [DW-1:0]    rf_rdata,
  output logic             rf_we,
  output logic [AW-1:0]    rf_waddr,
  output logic [DW-1:0]    rf_wdata,
  output logic             busy,
  output logic             done
);

  logic [NTAG-1:0] tv;
  logic [AW-1:0]   tk [NTAG];
  logic [AW-1:0]   sq, dq;
  logic            svq, dvq, sdone;
  logic [MW-1:0]   spm, dpm;
  logic [LW-1:0]   vlq, si, di;
  logic            s_vec, d_vec, fin, go, sskip, dskip, wr, accept;

  always_comb begin
    s_vec = 1'b0;
    d_vec = 1'b0;
    for (int i = 0; i < NTAG; i++) begin
      if (tv[i] && tk[i] == src_reg) s_vec = 1'b1;
      if (tv[i] && tk[i] == dst_reg) d_vec = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tv <= '0;
    else if (tag_we) begin
      tv[tag_slot] <= tag_on;
      tk[tag_slot] <= tag_reg;
    end
  end

  assign accept   = start && !busy;
  assign fin      = (si >= vlq) || (di >= vlq) || sdone;
  assign go       = busy && !fin;
  assign sskip    = !spm[si];
  assign dskip    = !dpm[di];
  assign wr       = go && !sskip && !dskip;
  assign rf_raddr = sq + (svq ? AW'(si) : '0);
  assign rf_waddr = dq + (dvq ? AW'(di) : '0);
  assign rf_we    = wr;
  assign rf_wdata = rf_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      si    <= '0;
      di    <= '0;
      sdone <= 1'b0;
      svq   <= 1'b0;
      dvq   <= 1'b0;
      sq    <= '0;
      dq    <= '0;
      vlq   <= '0;
      spm   <= '0;
      dpm   <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        si    <= '0;
        di    <= '0;
        sdone <= 1'b0;
        svq   <= s_vec;
        dvq   <= d_vec;
        sq    <= src_reg;
        dq    <= dst_reg;
        vlq   <= vl;
        spm   <= (src_pred_en && s_vec) ? MW'(src_pred) : '1;
        dpm   <= (dst_pred_en && d_vec) ? MW'(dst_pred) : '1;
      end else if (busy && fin) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (go) begin
        if (sskip) si <= si + 1'b1;
        else if (dskip) di <= di + 1'b1;
        else begin
          if (svq) si <= si + 1'b1;
          if (dvq) di <= di + 1'b1;
          else sdone <= 1'b1;
        end
      end
    end
  end

  AST_VL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> vl <= LW'(MAXVL)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rf_we); // R10
  AST_WRITE_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && dvq) |-> (rf_waddr - dq) < AW'(vlq)); // R10
  AST_SCALAR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && !dvq) |=> !rf_we); // R8
  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && spm == '0) |-> !rf_we); // R9
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin && start) |=> ($stable(sq) && $stable(dq) && busy)); // R11

endmodule

// File: tb/sim_pred_move_seq.sv
module sim_pred_move_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16, AW = 5, MAXVL = 8, NTAG = 4;
  localparam int LW = $clog2(MAXVL + 1);
  localparam int TW = $clog2(NTAG);
  localparam int NR = 1 << AW;
  localparam int SB = 2, DB = 16;

  logic clk = 0, rst_n = 0;
  logic tag_we = 0, tag_on = 0, start = 0, src_pred_en = 0, dst_pred_en = 0;
  logic [TW-1:0] tag_slot = '0;
  logic [AW-1:0] tag_reg = '0, src_reg = '0, dst_reg = '0;
  logic [MAXVL-1:0] src_pred = '0, dst_pred = '0;
  logic [LW-1:0] vl = '0;
  logic [AW-1:0] rf_raddr, rf_waddr;
  logic [DW-1:0] rf_rdata, rf_wdata;
  logic rf_we, busy, done;

  logic [DW-1:0] rf [NR];
  logic [DW-1:0] mr [NR];
  int checks = 0, errors = 0;
  bit timed_out = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_move_seq #(.DW(DW), .AW(AW), .MAXVL(MAXVL), .NTAG(NTAG)) u0 (
    .clk(clk), .rst_n(rst_n), .tag_we(tag_we), .tag_slot(tag_slot), .tag_reg(tag_reg),
    .tag_on(tag_on), .start(start), .src_reg(src_reg), .dst_reg(dst_reg),
    .src_pred_en(src_pred_en), .src_pred(src_pred), .dst_pred_en(dst_pred_en),
    .dst_pred(dst_pred), .vl(vl), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .busy(busy), .done(done));

  assign rf_rdata = rf[rf_raddr];
  always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_tag(input int slot, input int r, input bit on);
    @(negedge clk);
    tag_we = 1; tag_slot = TW'(slot); tag_reg = AW'(r); tag_on = on;
    @(negedge clk);
    tag_we = 0;
  endtask

  task automatic model(input int c, input int n, input bit spe, input logic [7:0] sp,
                       input bit dpe, input logic [7:0] dp);
    int j;
    if (n == 0) return;
    case (c)
      0: mr[DB] = mr[SB];
      1: for (int i = 0; i < n; i++) if (!dpe || dp[i]) mr[DB+i] = mr[SB];
      2: begin
        if (!spe) mr[DB] = mr[SB];
        else for (int i = 0; i < n; i++) if (sp[i]) begin mr[DB] = mr[SB+i]; break; end
      end
      default: begin
        j = 0;
        for (int i = 0; i < n; i++) begin
          if (spe && !sp[i]) continue;
          while (j < n && dpe && !dp[j]) j++;
          if (j >= n) break;
          mr[DB+j] = mr[SB+i];
          j++;
        end
      end
    endcase
  endtask

  task automatic run_op(input int c, input int n, input int pm, input int m, input int seed);
    logic [7:0] sp, dp;
    bit spe, dpe;
    int cyc, bad;
    string req;
    spe = pm[0]; dpe = pm[1];
    sp = (m == 0) ? 8'h00 : 8'((m * 37 + n * 11) & 255);
    dp = (m == 0) ? 8'h00 : ((m % 4 == 1) ? 8'(1 << ((m >> 2) & 7)) : 8'((m * 53 + 5) & 255));
    // R1: source tag in slot 0 or only through the duplicate in slot 2
    set_tag(0, SB, c[1] && m[0]);
    set_tag(2, SB, c[1]);
    set_tag(1, DB, c[0]);
    set_tag(3, 29, 1'b1);
    @(negedge clk);
    for (int i = 0; i < NR; i++) begin
      rf[i] = DW'(i * 97 + seed * 13 + 5);
      mr[i] = rf[i];
    end
    model(c, n, spe, sp, dpe, dp);
    src_reg = AW'(SB); dst_reg = AW'(DB); vl = LW'(n);
    src_pred_en = spe; src_pred = sp; dst_pred_en = dpe; dst_pred = dp;
    start = 1;
    @(negedge clk);
    src_reg = 1; dst_reg = 0; vl = LW'(MAXVL); src_pred_en = 0; dst_pred_en = 0; // R11
    @(negedge clk);
    start = 0;
    cyc = 2;
    while (!done && cyc < 40) begin @(negedge clk); cyc++; end
    if (c == 0) req = "R8";
    else if (c == 1) req = dpe ? "R3" : "R2";
    else if (c == 2) req = "R4";
    else if (pm == 0) req = "R5";
    else if (pm == 2) req = "R7";
    else req = "R6";
    if (m == 0 && pm != 0 && n > 0 && ((spe && c[1]) || (dpe && c[0]))) req = "R9";
    check(done && cyc <= 2 * n + 4, "R10", "done within bound", cyc, 2 * n + 4);
    @(negedge clk);
    check(!done && !busy, "R10", "done single pulse", done, 0);
    bad = -1;
    for (int i = 0; i < NR; i++) if (rf[i] !== mr[i] && bad < 0) bad = i;
    check(bad < 0, req, $sformatf("rf mismatch c=%0d vl=%0d pm=%0d m=%0d at reg", c, n, pm, m),
          bad, (bad < 0) ? 0 : int'(mr[bad]));
    check(rf[0] === mr[0], "R11", "restart ignored reg0", rf[0], mr[0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !rf_we, "R10", "reset state", {busy, done, rf_we}, 0);
    rst_n = 1;
    for (int n = 0; n <= MAXVL; n++)
      for (int c = 0; c < 4; c++)
        for (int pm = 0; pm < 4; pm++)
          for (int m = 0; m < 16; m++)
            if (!timed_out) run_op(c, n, pm, m, n * 64 + c * 16 + m);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    timed_out = 1;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule